// File: doc/BRIEF.md
# Power-up Reset Timing Sequencer

This block produces the hold signal that keeps a small microcontroller core in reset while the chip powers up. A power-on pulse from the supply detector starts the sequence. The sequence has two stages, and each stage can be skipped.

The first stage is a power-up delay. It counts ticks of a slow, free-running on-chip RC oscillator. That oscillator is asynchronous to the core, so each tick is brought into the main clock domain through a flop synchronizer before it is counted. A configuration bit can skip this stage.

The second stage is an oscillator start-up delay. It counts main-oscillator clock cycles and gives a crystal or resonator time to settle. It runs only in the crystal modes. Besides the power-on sequence, a wake-up from sleep also starts this second stage on its own. It then holds the core in the same way.

An active-low external clear pin can also hold the core. The pin first passes through a synchronizer and a stability filter. A low level holds the core only after it has been seen for a set number of consecutive cycles, so short glitches are rejected. When the clear is released, a power-on sequence that it interrupted starts again from the beginning. A clear that arrived during normal running releases the core at once.

The power-on pulse, the wake request and the configuration inputs are assumed to be synchronous to the main clock. Only the RC clock and the clear pin are treated as asynchronous.

Top module: `porst_seq`

## Requirements
- R1: After the synchronous reset `rst_n` is released, `core_hold_o` is 1 and stays 1 until a power-on pulse has been seen. The clear pin and wake requests have no effect in this state.
- R2: While `por_i` is 1, `core_hold_o` is 1. After `por_i` falls with `pwrt_off_i` = 0, `core_hold_o` stays 1 for at least `PWRT_COUNT` rising edges of `rc_clk_i`, plus any start-up delay. It falls only when `por_i` was 0 in the previous cycle.
- R3: With `pwrt_off_i` = 1 the power-up delay is skipped. In RC mode, `core_hold_o` falls on the first clock edge that samples `por_i` low.
- R4: `osc_mode_i` encodes 00 = low-power crystal, 01 = crystal, 10 = high-speed crystal and 11 = RC. In the three crystal modes the start-up delay follows the power-up delay, or follows the power-on pulse directly when the power-up delay is skipped. It holds the core for exactly `OST_COUNT` clock cycles, so `core_hold_o` falls `OST_COUNT`+1 edges after `por_i` is sampled low when `pwrt_off_i` = 1.
- R5: In RC mode (11) the start-up delay never runs.
- R6: A one-cycle `wake_i` pulse while the core runs in a crystal mode raises `core_hold_o` on that edge. It lowers it again `OST_COUNT`+1 edges after the pulse edge. No power-up delay runs on wake.
- R7: A `wake_i` pulse in RC mode leaves `core_hold_o` at 0.
- R8: A low level on `ext_clr_n_i` that is sampled on fewer than `CLR_FILTER` consecutive edges does not raise `core_hold_o`.
- R9: A low level on `ext_clr_n_i` that is held raises `core_hold_o` exactly `CLR_FILTER`+3 edges after it is first sampled, and holds it there while the pin stays low. After release during normal running, `core_hold_o` falls 4 edges after the pin is first sampled high.
- R10: A clear that interrupts an unfinished power-on sequence restarts that sequence on release. With `pwrt_off_i` = 1 in a crystal mode, `core_hold_o` falls `OST_COUNT`+4 edges after the pin is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Synchronous active-low logic reset |
| por_i | input | 1 | Power-on pulse from the supply-rise detector; sequence starts on its release |
| ext_clr_n_i | input | 1 | Asynchronous active-low external clear pin |
| pwrt_off_i | input | 1 | 1 skips the power-up delay, 0 runs it |
| osc_mode_i | input | 2 | Oscillator mode: 00 low-power crystal, 01 crystal, 10 high-speed crystal, 11 RC |
| rc_clk_i | input | 1 | Free-running on-chip RC oscillator, asynchronous |
| wake_i | input | 1 | One-cycle wake-from-sleep request |
| core_hold_o | output | 1 | 1 holds the core in reset |

## Verification
The filtered external clear and the start-up countdown can both be active in the same stretch of cycles. The bench provokes this by pulling the clear pin low a few cycles into a power-on start-up count, holding it until the hold has been taken over by the clear, and then releasing it. The outcome is judged by an exact cycle count: on release, the count must start again from zero and not resume from where it stopped. So `core_hold_o` must fall exactly `OST_COUNT`+4 edges after the release is sampled. In the same way, a wake request that coincides with a mode change is judged by whether the hold rises at all.

// File: rtl/porst_seq_pkg.sv
// Package: shared types for the power-up reset sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package porst_seq_pkg;

    // Sequencer phases; any phase other than SQ_RUN holds the core.
    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,   // after logic reset, waiting for a power-on pulse
        SQ_POR  = 3'd1,   // power-on pulse present
        SQ_PWRT = 3'd2,   // counting RC ticks
        SQ_OST  = 3'd3,   // counting main clock cycles
        SQ_RUN  = 3'd4,   // core released
        SQ_CLR  = 3'd5    // external clear holding the core
    } seq_state_t;

    // Oscillator mode code that selects the RC oscillator (no start-up delay).
    localparam logic [1:0] OSC_MODE_RC = 2'b11;

endpackage : porst_seq_pkg

// File: rtl/porst_sync.sv
// Module: multi-flop synchronizer for asynchronous single-bit inputs.
// Assumes STAGES >= 2 and that the input changes slowly relative to clk.
module porst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];

endmodule : porst_sync

// File: rtl/porst_clr_filter.sv
// Module: stability filter for the synchronized external clear.
// A low level is accepted only after FILT_CYC consecutive low samples;
// a single high sample releases it. Assumes FILT_CYC >= 2.
module porst_clr_filter #(
    parameter int FILT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n_sync_i,
    output logic clr_act_o
);

    localparam int FW = $clog2(FILT_CYC);
    localparam logic [FW-1:0] FLAST = FW'(FILT_CYC - 1);

    logic [FW-1:0] low_cnt;

    // Count consecutive low samples and assert once the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            clr_act_o <= 1'b0;
        end else if (clr_n_sync_i) begin
            low_cnt   <= '0;
            clr_act_o <= 1'b0;
        end else if (low_cnt == FLAST) begin
            clr_act_o <= 1'b1;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

endmodule : porst_clr_filter

// File: rtl/porst_delay_cnt.sv
// Module: terminal-count delay counter.
// Counts step_i pulses while clr_i is low; done_o flags the step that
// completes LIMIT counts. Assumes LIMIT >= 2; clr_i returns it to zero.
module porst_delay_cnt #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output logic done_o
);

    localparam int CW = $clog2(LIMIT);
    localparam logic [CW-1:0] CLAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Advance on each step, wrap at the terminal count, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt <= '0;
        end else if (step_i) begin
            cnt <= (cnt == CLAST) ? '0 : cnt + 1'b1;
        end
    end

    assign done_o = step_i && (cnt == CLAST);

endmodule : porst_delay_cnt

// File: rtl/porst_seq_fsm.sv
// Module: phase controller for the power-up reset sequence.
// Priority: power-on pulse, then filtered clear, then phase progress.
// Assumes por_i and wake_i are synchronous to clk.
module porst_seq_fsm
    import porst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_i,
    input  logic       clr_act_i,
    input  logic       pwrt_off_i,
    input  logic [1:0] osc_mode_i,
    input  logic       wake_i,
    input  logic       pwrt_done_i,
    input  logic       ost_done_i,
    output seq_state_t state_o,
    output logic       hold_o
);

    seq_state_t state, nxt, start_ph;
    logic       por_pend;
    logic       osc_rc;

    assign osc_rc = (osc_mode_i == OSC_MODE_RC);

    // First phase after a power-on pulse, chosen from the configuration.
    always_comb begin
        if (!pwrt_off_i)  start_ph = SQ_PWRT;
        else if (!osc_rc) start_ph = SQ_OST;
        else              start_ph = SQ_RUN;
    end

    // Next-phase selection with power-on and clear taking priority.
    always_comb begin
        nxt = state;
        if (por_i) begin
            nxt = SQ_POR;
        end else if (clr_act_i && state != SQ_IDLE) begin
            nxt = SQ_CLR;
        end else begin
            case (state)
                SQ_IDLE: nxt = SQ_IDLE;
                SQ_POR:  nxt = start_ph;
                SQ_PWRT: if (pwrt_done_i) nxt = osc_rc ? SQ_RUN : SQ_OST;
                SQ_OST:  if (ost_done_i)  nxt = SQ_RUN;
                SQ_RUN:  if (wake_i && !osc_rc) nxt = SQ_OST;
                SQ_CLR:  nxt = por_pend ? start_ph : SQ_RUN;
                default: nxt = SQ_IDLE;
            endcase
        end
    end

    // Phase register and registered hold output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            hold_o <= 1'b1;
        end else begin
            state  <= nxt;
            hold_o <= (nxt != SQ_RUN);
        end
    end

    // Remember an unfinished power-on sequence so a clear restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_pend <= 1'b0;
        end else if (por_i) begin
            por_pend <= 1'b1;
        end else if (nxt == SQ_RUN) begin
            por_pend <= 1'b0;
        end
    end

    assign state_o = state;

endmodule : porst_seq_fsm

// File: rtl/porst_seq.sv
// Module: power-up reset timing sequencer (top).
// Holds the core while a power-up delay (RC ticks) and a start-up delay
// (main clock cycles) run, and while a filtered external clear is low.
// Assumes rc_clk_i is much slower than clk; ext_clr_n_i is asynchronous.
module porst_seq
    import porst_seq_pkg::*;
#(
    parameter int PWRT_COUNT  = 1024,
    parameter int OST_COUNT   = 1024,
    parameter int CLR_FILTER  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_i,
    input  logic       ext_clr_n_i,
    input  logic       pwrt_off_i,
    input  logic [1:0] osc_mode_i,
    input  logic       rc_clk_i,
    input  logic       wake_i,
    output logic       core_hold_o
);

    logic       rc_sync, rc_prev, rc_rise;
    logic       clr_sync, clr_act;
    logic       pwrt_done, ost_done;
    seq_state_t state;

    // Bring the RC oscillator into the clk domain.
    porst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_rc_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rc_clk_i), .q_o(rc_sync)
    );

    // Bring the clear pin into the clk domain (idle high).
    porst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_clr_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ext_clr_n_i), .q_o(clr_sync)
    );

    // Delay the synchronized RC level by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rc_prev <= 1'b0;
        else        rc_prev <= rc_sync;
    end

    assign rc_rise = rc_sync & ~rc_prev;

    porst_clr_filter #(.FILT_CYC(CLR_FILTER)) i_filt (
        .clk(clk), .rst_n(rst_n), .clr_n_sync_i(clr_sync), .clr_act_o(clr_act)
    );

    porst_delay_cnt #(.LIMIT(PWRT_COUNT)) i_pwrt_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(state != SQ_PWRT),
        .step_i(rc_rise), .done_o(pwrt_done)
    );

    porst_delay_cnt #(.LIMIT(OST_COUNT)) i_ost_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(state != SQ_OST),
        .step_i(1'b1), .done_o(ost_done)
    );

    porst_seq_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .por_i(por_i), .clr_act_i(clr_act),
        .pwrt_off_i(pwrt_off_i), .osc_mode_i(osc_mode_i), .wake_i(wake_i),
        .pwrt_done_i(pwrt_done), .ost_done_i(ost_done),
        .state_o(state), .hold_o(core_hold_o)
    );

endmodule : porst_seq

// File: rtl/porst_seq_chk.sv
// Module: property checker for porst_seq, attached by bind below.
// Observes ports plus the synchronized and filtered clear signals.
module porst_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_i,
    input logic [1:0] osc_mode_i,
    input logic       wake_i,
    input logic       core_hold_o,
    input logic       clr_sync,
    input logic       clr_act
);

    // R2: a power-on pulse always holds the core on the next cycle.
    p_por_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> core_hold_o);

    // R2: the hold never drops right after a power-on pulse was present.
    p_fall_no_por_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_hold_o) |-> !$past(por_i));

    // R6: wake while running in a crystal mode raises the hold.
    p_wake_ost_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_hold_o && wake_i && osc_mode_i != 2'b11 && !por_i && !clr_act)
        |=> core_hold_o);

    // R7: wake while running in RC mode leaves the core running.
    p_wake_rc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_hold_o && wake_i && osc_mode_i == 2'b11 && !por_i && !clr_act)
        |=> !core_hold_o);

    // R8: the filter only asserts after the synchronized pin was low.
    p_filter_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_act) |-> !$past(clr_sync));

    // R9: an accepted clear holds the core on the next cycle.
    p_clr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> core_hold_o);

endmodule : porst_seq_chk

bind porst_seq porst_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .osc_mode_i(osc_mode_i),
    .wake_i(wake_i), .core_hold_o(core_hold_o),
    .clr_sync(clr_sync), .clr_act(clr_act)
);

// File: tb/test_porst_seq.sv
module test_porst_seq;

    localparam int PW   = 8;
    localparam int OST  = 16;
    localparam int FILT = 4;
    localparam int LIM  = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por = 1'b0;
    logic       clr_n = 1'b1;
    logic       pwrt_off = 1'b1;
    logic [1:0] mode = 2'b11;
    logic       rc_clk = 1'b0;
    logic       wake = 1'b0;
    logic       hold;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always #17 rc_clk = ~rc_clk;

    porst_seq #(.PWRT_COUNT(PW), .OST_COUNT(OST), .CLR_FILTER(FILT)) i_porst_seq (
        .clk(clk), .rst_n(rst_n), .por_i(por), .ext_clr_n_i(clr_n),
        .pwrt_off_i(pwrt_off), .osc_mode_i(mode), .rc_clk_i(rc_clk),
        .wake_i(wake), .core_hold_o(hold)
    );

    // Power-on table: configuration and allowed hold length in edges.
    localparam int NV = 6;
    localparam int TV_OFF [NV] = '{1, 1, 1, 1, 0, 0};
    localparam int TV_MODE[NV] = '{0, 1, 2, 3, 3, 1};
    localparam int TV_LO  [NV] = '{OST+1, OST+1, OST+1, 1,
                                   1+(PW-1)*8, 1+(PW-1)*8+OST};
    localparam int TV_HI  [NV] = '{OST+1, OST+1, OST+1, 1,
                                   1+PW*9+4, 1+PW*9+4+OST};
    // Row tags: 0..2 R4 (LP/XT/HS), 3 R3 and R5, 4 R2, 5 R2 with R4.
    localparam int TV_REQ [NV] = '{4, 4, 4, 5, 2, 2};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Count edges until hold reaches the given level.
    task automatic wait_hold(input logic lvl, output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (hold != lvl && n < LIM);
    endtask

    task automatic power_on(input logic off, input logic [1:0] m, output int n);
        pwrt_off = off;
        mode = m;
        por = 1'b1;
        tick();
        por = 1'b0;
        wait_hold(1'b0, n);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            report();
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(hold == 1'b1, "R1 reset hold", hold, 1);
        wake = 1'b1;
        clr_n = 1'b0;
        repeat (FILT + 6) tick();
        wake = 1'b0;
        clr_n = 1'b1;
        repeat (6) tick();
        chk(hold == 1'b1, "R1 idle until power-on", hold, 1);

        // Table walk over oscillator modes and power-up delay setting.
        for (int i = 0; i < NV; i++) begin
            power_on(TV_OFF[i][0], TV_MODE[i][1:0], n);
            chk(n >= TV_LO[i] && n <= TV_HI[i], $sformatf("R%0d row %0d", TV_REQ[i], i),
                n, TV_LO[i]);
            repeat (3) tick();
        end

        // R2: held for as long as the power-on pulse lasts.
        pwrt_off = 1'b1;
        mode = 2'b11;
        por = 1'b1;
        repeat (10) tick();
        chk(hold == 1'b1, "R2 held during pulse", hold, 1);
        por = 1'b0;
        tick();
        chk(hold == 1'b0, "R3 release after pulse", hold, 0);

        // R6: wake in crystal mode holds for the start-up count only.
        mode = 2'b01;
        tick();
        wake = 1'b1;
        tick();
        wake = 1'b0;
        chk(hold == 1'b1, "R6 wake raises hold", hold, 1);
        wait_hold(1'b0, n);
        chk(n + 1 == OST + 1, "R6 wake length", n + 1, OST + 1);

        // R7: wake in RC mode has no effect.
        mode = 2'b11;
        tick();
        wake = 1'b1;
        tick();
        wake = 1'b0;
        chk(hold == 1'b0, "R7 wake ignored", hold, 0);
        repeat (4) tick();
        chk(hold == 1'b0, "R7 still running", hold, 0);

        // R8: short clear glitch is filtered out.
        clr_n = 1'b0;
        repeat (FILT - 1) tick();
        clr_n = 1'b1;
        n = 0;
        for (int k = 0; k < 10; k++) begin
            if (hold) n++;
            tick();
        end
        chk(n == 0, "R8 glitch rejected", n, 0);

        // R9: held clear raises hold after the filter and releases at once.
        clr_n = 1'b0;
        wait_hold(1'b1, n);
        chk(n == FILT + 3, "R9 clear delay", n, FILT + 3);
        repeat (20) tick();
        chk(hold == 1'b1, "R9 held while low", hold, 1);
        clr_n = 1'b1;
        wait_hold(1'b0, n);
        chk(n == 4, "R9 release from run", n, 4);

        // R10: clear during power-on start-up restarts the count.
        pwrt_off = 1'b1;
        mode = 2'b10;
        por = 1'b1;
        tick();
        por = 1'b0;
        repeat (2) tick();
        clr_n = 1'b0;
        repeat (FILT + 5) tick();
        chk(hold == 1'b1, "R10 held by clear", hold, 1);
        clr_n = 1'b1;
        wait_hold(1'b0, n);
        chk(n == OST + 4, "R10 restarted start-up", n, OST + 4);

        done = 1'b1;
        report();
        $finish;
    end

endmodule : test_porst_seq